// File: doc/BRIEF.md
# Slot Reset Power-Up Sequencer

This block sits on the root-port side of a PCIe slot and brings the attached endpoint out of reset in a safe, timed order. After a start request it keeps the fundamental reset (PERST#, active low) asserted. It then switches on slot power and, once power is good, enables the reference clock. It releases PERST# only after power has been good for a long settling window and the reference clock has been stable for a short one. Each window carries an extra margin count to cover how long the board's own circuits take to go from enabled to stable.

After release, the sequencer chooses how long to wait before configuration requests are allowed. The choice depends on the root port's own maximum-speed strap, not on the attached device. For a port whose top speed is above 5 GT/s, it waits for Data Link Layer Link Active, then applies a settle wait. If Link Active does not arrive within a timeout, it raises an error. For slower ports, a settle wait counted from the release alone grants configuration.

Dropping the start request, or losing power-good once it has been seen, returns the machine to idle at once. All windows are counted in clock cycles from parameters.

Top module: `slot_reset_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pwr_en`, `refclk_en`, `perst_n`, `cfg_ready` and `seq_err` are all 0.
- R2: One cycle after `start_req` is sampled high in idle, `pwr_en` is 1 while `perst_n` and `refclk_en` are still 0. `refclk_en` stays 0 until `pwr_good` has been sampled high.
- R3: `perst_n` rises exactly PWR_WAIT_CYC+PWR_MARGIN_CYC+1 cycles after the first clock edge that samples `pwr_good` high with power enabled, when the clock window is already satisfied.
- R4: `perst_n` rises exactly CLK_WAIT_CYC+CLK_MARGIN_CYC+1 cycles after the edge that samples `clk_stable` high with the clock enabled, when the power window is already satisfied. A cycle with `clk_stable` low restarts that window.
- R5: `perst_n` is released only when both windows have expired. With the power window long past, it stays low for as long as `clk_stable` is low.
- R6: With `max_speed` above 5 GT/s, `cfg_ready` stays 0 until `link_active` is seen. If `link_active` is not seen within LINK_TMO_CYC+1 cycles of release, `seq_err` rises and `perst_n` is driven low again. `max_speed` is coded 1=2.5, 2=5, 3=8, 4=16, 5=32 GT/s, and any code above 2 counts as fast.
- R7: With a fast `max_speed`, `cfg_ready` rises exactly SETTLE_CYC+2 cycles after `link_active` is driven high.
- R8: With `max_speed` of 2 or less, `cfg_ready` rises exactly SETTLE_CYC+1 cycles after release, whatever `link_active` does, and `seq_err` never rises.
- R9: `start_req` sampled low in any state returns the block to idle in the next cycle: power, clock, PERST# release and both flags are all 0. This also clears `seq_err`.
- R10: After `pwr_good` has been seen, a cycle with `pwr_good` low returns the block to idle in the next cycle. If `start_req` is still high, a fresh sequence starts the cycle after that.
- R11: `cfg_ready` is only ever high with `perst_n`, `pwr_en` and `refclk_en` high. `cfg_ready` and `seq_err` are never high together, and `refclk_en` is never high without `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to bring up the slot; low forces idle |
| pwr_good | input | 1 | Slot power within limits |
| clk_stable | input | 1 | Reference clock stable |
| link_active | input | 1 | Data Link Layer Link Active status |
| max_speed | input | 3 | Root port maximum speed strap (1..5 = 2.5..32 GT/s) |
| pwr_en | output | 1 | Slot power enable |
| refclk_en | output | 1 | Reference clock enable |
| perst_n | output | 1 | Fundamental reset, active low |
| cfg_ready | output | 1 | Configuration requests may be issued |
| seq_err | output | 1 | Link Active timeout |

## Verification
A wrong state shows at the ports at the next edge, because every output decodes the registered state directly. A state entered too early or skipped shows as `perst_n` or `cfg_ready` rising on a different cycle than the window arithmetic predicts. For that reason, release and readiness are measured to the exact cycle from the triggering input. A miscounted or uncleared timer shifts those edges by at least one cycle, and a wrong speed decision shows as readiness that depends, or fails to depend, on `link_active`.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    localparam int SPEED_W = 3;
    localparam logic [SPEED_W-1:0] SPEED_CODE_5G = 3'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_CLK_HOLD,
        ST_LINK_WAIT,
        ST_SETTLE,
        ST_READY,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic pwr_en;
        logic refclk_en;
        logic perst_n;
        logic cfg_ready;
        logic err;
    } seq_out_t;

    function automatic logic speed_is_fast(input logic [SPEED_W-1:0] code);
        return code > SPEED_CODE_5G;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic seq_out_t decode_outputs(input seq_state_e s);
        seq_out_t o;
        o = '0;
        case (s)
            ST_PWR_UP:    o.pwr_en = 1'b1;
            ST_CLK_HOLD:  begin o.pwr_en = 1'b1; o.refclk_en = 1'b1; end
            ST_LINK_WAIT,
            ST_SETTLE:    begin o.pwr_en = 1'b1; o.refclk_en = 1'b1; o.perst_n = 1'b1; end
            ST_READY:     begin o.pwr_en = 1'b1; o.refclk_en = 1'b1; o.perst_n = 1'b1; o.cfg_ready = 1'b1; end
            ST_FAULT:     begin o.pwr_en = 1'b1; o.refclk_en = 1'b1; o.err = 1'b1; end
            default:      o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/slot_seq_timer.sv
module slot_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q >= limit);
endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
    import slot_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       pwr_good,
    input  logic       link_active,
    input  logic       fast_port,
    input  logic       pwr_done,
    input  logic       clk_done,
    input  logic       ph_done,
    output seq_state_e state_q
);
    seq_state_e nxt;
    logic       pwr_seen;

    // Power-good has been observed once the machine is past the power-up step.
    assign pwr_seen = (state_q != ST_IDLE) && (state_q != ST_PWR_UP);

    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE:      if (start_req) nxt = ST_PWR_UP;
            ST_PWR_UP:    if (pwr_good) nxt = ST_CLK_HOLD;
            ST_CLK_HOLD:  if (pwr_done && clk_done)
                              nxt = fast_port ? ST_LINK_WAIT : ST_SETTLE;
            ST_LINK_WAIT: begin
                if (link_active)  nxt = ST_SETTLE;
                else if (ph_done) nxt = ST_FAULT;
            end
            ST_SETTLE:    if (ph_done) nxt = ST_READY;
            default:      nxt = state_q;
        endcase
        // Abort paths take priority over every forward step.
        if (!start_req || (pwr_seen && !pwr_good)) begin
            nxt = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= nxt;
    end
endmodule

// File: rtl/slot_reset_seq.sv
module slot_reset_seq
    import slot_seq_pkg::*;
#(
    parameter int unsigned PWR_WAIT_CYC   = 10_000_000,
    parameter int unsigned PWR_MARGIN_CYC = 0,
    parameter int unsigned CLK_WAIT_CYC   = 10_000,
    parameter int unsigned CLK_MARGIN_CYC = 0,
    parameter int unsigned LINK_TMO_CYC   = 10_000_000,
    parameter int unsigned SETTLE_CYC     = 10_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               pwr_good,
    input  logic               clk_stable,
    input  logic               link_active,
    input  logic [SPEED_W-1:0] max_speed,
    output logic               pwr_en,
    output logic               refclk_en,
    output logic               perst_n,
    output logic               cfg_ready,
    output logic               seq_err
);
    localparam int unsigned PWR_LIM = PWR_WAIT_CYC + PWR_MARGIN_CYC;
    localparam int unsigned CLK_LIM = CLK_WAIT_CYC + CLK_MARGIN_CYC;
    localparam int unsigned MAX_LIM = max_of(max_of(PWR_LIM, CLK_LIM),
                                             max_of(LINK_TMO_CYC, SETTLE_CYC));
    localparam int unsigned CW      = $clog2(MAX_LIM + 1);
    localparam int unsigned NWIN    = 2;

    seq_state_e state_q;
    seq_out_t   outs;

    logic [NWIN-1:0] win_clr;
    logic [NWIN-1:0] win_done;
    logic [CW-1:0]   win_lim [NWIN];

    logic          ph_clr;
    logic          ph_done;
    logic [CW-1:0] ph_lim;

    assign outs = decode_outputs(state_q);

    // Window 0: power settling, runs while power is enabled and good.
    // Window 1: clock settling, runs while the clock is enabled and stable.
    assign win_clr[0] = !(outs.pwr_en && pwr_good);
    assign win_clr[1] = !(outs.refclk_en && clk_stable);
    assign win_lim[0] = CW'(PWR_LIM);
    assign win_lim[1] = CW'(CLK_LIM);

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        slot_seq_timer #(.CW(CW)) u_win (
            .clk   (clk),
            .rst   (rst),
            .clr   (win_clr[i]),
            .limit (win_lim[i]),
            .done  (win_done[i])
        );
    end

    // Post-release phase timer: timeout while waiting for the link, then the
    // settle wait. It restarts when the link arrives.
    assign ph_clr = !((state_q == ST_LINK_WAIT) || (state_q == ST_SETTLE))
                    || ((state_q == ST_LINK_WAIT) && link_active);
    assign ph_lim = (state_q == ST_LINK_WAIT) ? CW'(LINK_TMO_CYC) : CW'(SETTLE_CYC);

    slot_seq_timer #(.CW(CW)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr   (ph_clr),
        .limit (ph_lim),
        .done  (ph_done)
    );

    slot_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .pwr_good    (pwr_good),
        .link_active (link_active),
        .fast_port   (speed_is_fast(max_speed)),
        .pwr_done    (win_done[0]),
        .clk_done    (win_done[1]),
        .ph_done     (ph_done),
        .state_q     (state_q)
    );

    assign pwr_en    = outs.pwr_en;
    assign refclk_en = outs.refclk_en;
    assign perst_n   = outs.perst_n;
    assign cfg_ready = outs.cfg_ready;
    assign seq_err   = outs.err;
endmodule

// File: rtl/slot_seq_checker.sv
module slot_seq_checker (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic pwr_good,
    input logic clk_stable,
    input logic link_active,
    input logic pwr_en,
    input logic refclk_en,
    input logic perst_n,
    input logic cfg_ready,
    input logic seq_err
);
    // R2: power comes on while the reset is still held and the clock is off
    a_r2_power_under_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> (!perst_n && !refclk_en));

    // R2: the clock is enabled only after power-good was sampled
    a_r2_clock_after_power: assert property (@(posedge clk) disable iff (rst)
        $rose(refclk_en) |-> $past(pwr_good));

    // R3, R4, R5: release happens only with both power and clock good
    a_r5_release_needs_both: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_n) |-> ($past(pwr_good) && $past(clk_stable)));

    // R6: a timeout is flagged only when the link was not active
    a_r6_timeout_without_link: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> !$past(link_active));

    // R9: a dropped request returns everything to idle
    a_r9_abort_on_request: assert property (@(posedge clk) disable iff (rst)
        !start_req |=> (!pwr_en && !refclk_en && !perst_n && !cfg_ready && !seq_err));

    // R10: power loss after bring-up returns to idle
    a_r10_abort_on_power: assert property (@(posedge clk) disable iff (rst)
        (refclk_en && !pwr_good) |=> (!pwr_en && !perst_n && !cfg_ready));

    // R11: output consistency
    a_r11_ready_consistent: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> (perst_n && pwr_en && refclk_en && !seq_err));

    a_r11_clock_needs_power: assert property (@(posedge clk) disable iff (rst)
        refclk_en |-> pwr_en);
endmodule

bind slot_reset_seq slot_seq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .pwr_good    (pwr_good),
    .clk_stable  (clk_stable),
    .link_active (link_active),
    .pwr_en      (pwr_en),
    .refclk_en   (refclk_en),
    .perst_n     (perst_n),
    .cfg_ready   (cfg_ready),
    .seq_err     (seq_err)
);

// File: tb/slot_reset_seq_tb_top.sv
module slot_reset_seq_tb_top;
    localparam int PW = 40, PM = 3, CWT = 10, CM = 2, TMO = 50, ST = 30;
    localparam int LP = PW + PM;
    localparam int LC = CWT + CM;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, pwr_good = 1'b0, clk_stable = 1'b0, link_active = 1'b0;
    logic [2:0] max_speed = 3'd1;
    logic pwr_en, refclk_en, perst_n, cfg_ready, seq_err;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    slot_reset_seq #(
        .PWR_WAIT_CYC(PW), .PWR_MARGIN_CYC(PM),
        .CLK_WAIT_CYC(CWT), .CLK_MARGIN_CYC(CM),
        .LINK_TMO_CYC(TMO), .SETTLE_CYC(ST)
    ) dut_i (
        .clk(clk), .rst(rst), .start_req(start_req), .pwr_good(pwr_good),
        .clk_stable(clk_stable), .link_active(link_active), .max_speed(max_speed),
        .pwr_en(pwr_en), .refclk_en(refclk_en), .perst_n(perst_n),
        .cfg_ready(cfg_ready), .seq_err(seq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outv();
        return {pwr_en, refclk_en, perst_n, cfg_ready, seq_err};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_req = 0; pwr_good = 0; clk_stable = 0; link_active = 0;
        repeat (3) @(negedge clk);
        check(outv() == 0, "R1 outputs in reset", outv(), 0);
        rst = 1'b0;
        @(negedge clk);
        check(outv() == 0, "R1 outputs after reset", outv(), 0);
    endtask

    // Start, check power-under-reset, then raise power-good (and optionally the clock).
    task automatic start_power(input logic [2:0] spd, input bit with_clk);
        max_speed = spd;
        start_req = 1'b1;
        @(negedge clk);
        check(pwr_en && !perst_n && !refclk_en, "R2 power on under reset",
              outv(), 5'b10000);
        repeat (3) @(negedge clk);
        check(!refclk_en, "R2 clock waits for power-good", refclk_en, 0);
        pwr_good = 1'b1;
        clk_stable = with_clk;
    endtask

    task automatic count_until_release(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!perst_n && n < 1000);
    endtask

    task automatic count_until_ready(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!cfg_ready && n < 1000);
    endtask

    task automatic t_fast_ready();
        int n;
        do_reset();
        start_power(3'd3, 1'b1);
        count_until_release(n);
        check(n == LP + 1, "R3 power window release cycle", n, LP + 1);
        repeat (5) @(negedge clk);
        check(!cfg_ready && !seq_err, "R6 fast port waits for link", outv(), 5'b11100);
        link_active = 1'b1;
        count_until_ready(n);
        check(n == ST + 2, "R7 ready after link plus settle", n, ST + 2);
        // R9: drop the request from the ready state
        start_req = 1'b0;
        @(negedge clk);
        check(outv() == 0, "R9 request drop returns to idle", outv(), 0);
    endtask

    task automatic t_clk_late();
        int n;
        do_reset();
        start_power(3'd1, 1'b0);
        repeat (LP + 10) @(negedge clk);
        check(!perst_n && refclk_en, "R5 held while clock not stable", perst_n, 0);
        clk_stable = 1'b1;
        count_until_release(n);
        check(n == LC + 1, "R4 clock window release cycle", n, LC + 1);
    endtask

    task automatic t_clk_glitch();
        int n;
        do_reset();
        start_power(3'd2, 1'b0);
        repeat (LP + 5) @(negedge clk);
        clk_stable = 1'b1;
        repeat (6) @(negedge clk);
        clk_stable = 1'b0;
        @(negedge clk);
        clk_stable = 1'b1;
        count_until_release(n);
        check(n == LC + 1, "R4 clock glitch restarts window", n, LC + 1);
    endtask

    task automatic t_slow(input logic [2:0] spd, input bit link_hi);
        int n;
        do_reset();
        link_active = link_hi;
        start_power(spd, 1'b1);
        count_until_release(n);
        check(n == LP + 1, "R3 release cycle slow port", n, LP + 1);
        count_until_ready(n);
        check(n == ST + 1, "R8 slow ready after settle", n, ST + 1);
        repeat (TMO + 10) @(negedge clk);
        check(cfg_ready && !seq_err, "R8 slow port never times out", seq_err, 0);
    endtask

    task automatic t_timeout();
        int n;
        do_reset();
        start_power(3'd4, 1'b1);
        count_until_release(n);
        n = 0;
        do begin @(negedge clk); n++; end while (!seq_err && n < 1000);
        check(n == TMO + 1, "R6 link timeout cycle", n, TMO + 1);
        check(!perst_n && !cfg_ready, "R6 reset reasserted on timeout", outv(), 5'b11001);
        link_active = 1'b1;
        repeat (3) @(negedge clk);
        check(seq_err && !cfg_ready, "R6 late link does not recover", outv(), 5'b11001);
        start_req = 1'b0;
        @(negedge clk);
        check(outv() == 0, "R9 request drop clears error", outv(), 0);
    endtask

    task automatic t_power_loss();
        int n;
        do_reset();
        start_power(3'd1, 1'b1);
        count_until_release(n);
        count_until_ready(n);
        pwr_good = 1'b0;
        @(negedge clk);
        check(outv() == 0, "R10 power loss returns to idle", outv(), 0);
        @(negedge clk);
        check(pwr_en && !perst_n && !refclk_en, "R10 restart while request held",
              outv(), 5'b10000);
    endtask

    task automatic t_reset_mid();
        int n;
        do_reset();
        start_power(3'd1, 1'b1);
        count_until_release(n);
        count_until_ready(n);
        rst = 1'b1;
        @(negedge clk);
        check(outv() == 0, "R1 reset from ready state", outv(), 0);
        rst = 1'b0;
        start_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_fast_ready();
        t_clk_late();
        t_clk_glitch();
        t_slow(3'd2, 1'b0);
        t_slow(3'd1, 1'b1);
        t_timeout();
        t_power_loss();
        t_reset_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule